// File: doc/BRIEF.md
# Trace Flush and Stop Controller

This controller runs next to a trace capture path. It decides when to ask the upstream trace source for a flush and when capture must stop. A flush can be started in four ways: software writes a self-clearing manual bit, an internal trigger event occurs, the external flush pin has a rising edge, or the downstream side requests one. The block raises `flush_valid` and holds it until `flush_ready` comes back high. In formatted mode it then waits for the formatter to report that all flush data is drained, including the closing post-amble. After that the flush is complete.

When a flush completes, the manual bit clears. If stop-on-flush is set and the flush was started by a local source, capture enters the stopped state. A trigger event can also stop capture directly. Once stopped, the block ignores every flush source until software drops `capt_en` and raises it again. Only one flush is outstanding at a time. Requests that arrive while a flush is running are merged into it.

Control register bits at `cfg_wdata`/`cfg_rdata`: bit0 formatted mode, bit1 manual flush, bit2 flush-on-trigger, bit3 flush-on-pin, bit4 stop-on-flush, bit5 stop-on-trigger.

Top module: `trace_flush_ctrl`

## Requirements
- R1: After reset, `flush_valid`, `flush_busy`, `flush_done` and `stopped` are low and `cfg_rdata` reads 0.
- R2: A write with bit1 set sets the manual bit, and a flush begins one cycle later. The write is ignored when `capt_en` is low or the block is stopped, and bit1 then reads 0.
- R3: `flush_valid` stays high from the start of a flush until the edge where `flush_ready` is sampled high.
- R4: In bypass mode (bit0=0), a flush completes at the edge where `flush_ready` is sampled. At that edge the manual bit clears and `flush_done` goes high for exactly one cycle.
- R5: In formatted mode (bit0=1), `flush_valid` drops on `flush_ready`, but the flush stays busy and the manual bit stays set. Completion happens at the edge where `drain_done` is sampled high.
- R6: With bit3 set, a rising edge on `flush_pin` starts a flush two edges later (the pin is registered). A pin held high does not retrigger, and with bit3 clear the pin has no effect.
- R7: A `trig_evt` pulse starts a flush when bit2 is set and bit5 is clear. Bit2 is ignored while bit5 is set.
- R8: With bit5 set, a `trig_evt` pulse while `capt_en` is high makes `stopped` high at the next edge.
- R9: With bit4 set, completion of a flush started by a manual, trigger or pin source sets `stopped`. A flush requested only by `ds_flush_req` never sets `stopped`.
- R10: While stopped, no source starts a flush. `stopped` clears on the edge where `capt_en` is sampled low.
- R11: Requests that arrive during a flush are merged into it, and no second flush follows.
- R12: `cfg_rdata` returns the stored bits 0, 2, 3, 4 and 5 and the live manual bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| capt_en | input | 1 | Capture enabled by software |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 6 | Control register write data |
| cfg_rdata | output | 6 | Control register read data |
| trig_evt | input | 1 | Internal trigger event pulse |
| flush_pin | input | 1 | External flush request level |
| ds_flush_req | input | 1 | Downstream flush request pulse |
| flush_valid | output | 1 | Flush request to upstream source |
| flush_ready | input | 1 | Flush acknowledge from upstream |
| drain_done | input | 1 | Formatter reports flush data and post-amble written |
| flush_busy | output | 1 | A flush is in progress |
| flush_done | output | 1 | One-cycle pulse on flush completion |
| stopped | output | 1 | Capture stopped |

## Verification
On every cycle, the embedded assertions check four things: that `flush_valid` holds until it is acknowledged, that `flush_done` is a single-cycle pulse, that a stop-trigger always stops capture, and that a stopped, idle block never starts a flush. They also check that the manual bit survives the formatted-mode drain. Some behaviours only the bench scenarios can show. These are which source started a flush, whether its completion stops capture, the ignored writes and pin levels, and the absence of a second flush after merged requests. The bench sweeps every combination of mode, stop-on-flush and source.

// File: rtl/trace_flush_ctrl.sv
module trace_flush_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capt_en,
  input  logic       cfg_we,
  input  logic [5:0] cfg_wdata,
  output logic [5:0] cfg_rdata,
  input  logic       trig_evt,
  input  logic       flush_pin,
  input  logic       ds_flush_req,
  output logic       flush_valid,
  input  logic       flush_ready,
  input  logic       drain_done,
  output logic       flush_busy,
  output logic       flush_done,
  output logic       stopped
);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DRAIN} st_t;

  st_t  st_q;
  logic fmt_q, man_q, fot_q, fop_q, sof_q, sot_q;
  logic pin_q, pin_d, loc_q, done_q, stop_q;

  logic live, pin_rise, loc_req, any_req, stop_trig, fin, man_set;

  assign live      = capt_en & ~stop_q;
  assign pin_rise  = pin_q & ~pin_d;
  assign loc_req   = live & (man_q | (trig_evt & fot_q & ~sot_q) | (pin_rise & fop_q));
  assign any_req   = loc_req | (live & ds_flush_req);
  assign stop_trig = capt_en & trig_evt & sot_q;
  assign fin       = (st_q == ST_REQ & flush_ready & ~fmt_q) | (st_q == ST_DRAIN & drain_done);
  assign man_set   = cfg_we & cfg_wdata[1] & live;

  assign flush_valid = (st_q == ST_REQ);
  assign flush_busy  = (st_q != ST_IDLE);
  assign flush_done  = done_q;
  assign stopped     = stop_q;
  assign cfg_rdata   = {sot_q, sof_q, fop_q, fot_q, man_q, fmt_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {fmt_q, fot_q, fop_q, sof_q, sot_q} <= '0;
    end else if (cfg_we) begin
      fmt_q <= cfg_wdata[0];
      fot_q <= cfg_wdata[2];
      fop_q <= cfg_wdata[3];
      sof_q <= cfg_wdata[4];
      sot_q <= cfg_wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       man_q <= 1'b0;
    else if (man_set) man_q <= 1'b1;
    else if (fin)     man_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      pin_d <= 1'b0;
    end else begin
      pin_q <= flush_pin;
      pin_d <= pin_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      loc_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (any_req) begin
          st_q  <= ST_REQ;
          loc_q <= loc_req;
        end
        ST_REQ: begin
          loc_q <= loc_q | loc_req;
          if (flush_ready) st_q <= fmt_q ? ST_DRAIN : ST_IDLE;
        end
        ST_DRAIN: begin
          loc_q <= loc_q | loc_req;
          if (drain_done) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (!capt_en)
        stop_q <= 1'b0;
      else if (stop_trig | (fin & sof_q & (loc_q | loc_req)))
        stop_q <= 1'b1;
    end
  end

  p_valid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && !flush_ready |=> flush_valid);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  p_man_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN) && !drain_done && man_q |=> man_q);

  p_stop_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capt_en && trig_evt && sot_q |=> stopped);

  p_no_start_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stopped && !flush_busy |=> !flush_valid);

endmodule

// File: tb/test_trace_flush_ctrl.sv
module test_trace_flush_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic capt_en = 1'b0, cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0, cfg_rdata;
  logic trig_evt = 1'b0, flush_pin = 1'b0, ds_flush_req = 1'b0;
  logic flush_valid, flush_ready = 1'b0, drain_done = 1'b0;
  logic flush_busy, flush_done, stopped;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  trace_flush_ctrl i_trace_flush_ctrl (.*);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] v);
    cfg_wdata = v;
    cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic restart();
    capt_en = 1'b0;
    step();
    capt_en = 1'b1;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 valid", flush_valid, 0);
    chk("R1 busy", flush_busy, 0);
    chk("R1 done", flush_done, 0);
    chk("R1 stopped", stopped, 0);
    chk("R1 rdata", cfg_rdata, 0);
    rst_n = 1'b1;
    capt_en = 1'b1;
    step();

    for (int fmt = 0; fmt < 2; fmt++)
      for (int sof = 0; sof < 2; sof++)
        for (int src = 0; src < 4; src++) begin
          logic [5:0] base;
          base = 6'(fmt) | 6'h0C | (6'(sof) << 4);
          wr(base);
          case (src)
            0: begin
              wr(base | 6'h02);
              chk("R2 man set", cfg_rdata[1], 1);
              step();
            end
            1: begin trig_evt = 1'b1; step(); trig_evt = 1'b0; end
            2: begin flush_pin = 1'b1; step(); step(); end
            default: begin ds_flush_req = 1'b1; step(); ds_flush_req = 1'b0; end
          endcase
          chk(src == 1 ? "R7 start" : src == 2 ? "R6 start" : "R2 start", flush_valid, 1);
          step(); step(); step();
          chk("R3 hold", flush_valid, 1);
          flush_ready = 1'b1;
          step();
          flush_ready = 1'b0;
          chk("R3 drop", flush_valid, 0);
          if (fmt == 1) begin
            chk("R5 busy", flush_busy, 1);
            chk("R5 done", flush_done, 0);
            chk("R5 man held", cfg_rdata[1], src == 0);
            step(); step();
            drain_done = 1'b1;
            step();
            drain_done = 1'b0;
          end
          chk("R4 done", flush_done, 1);
          chk("R4 idle", flush_busy, 0);
          chk("R4 man clear", cfg_rdata[1], 0);
          chk("R9 stopped", stopped, (sof == 1 && src != 3));
          step();
          chk("R4 pulse", flush_done, 0);
          flush_pin = 1'b0;
          restart();
          chk("R10 restart", stopped, 0);
        end

    capt_en = 1'b0;
    wr(6'h02);
    chk("R2 ignored", cfg_rdata[1], 0);
    step();
    chk("R2 no flush", flush_valid, 0);
    capt_en = 1'b1;
    step();

    wr(6'h00);
    flush_pin = 1'b1;
    step(); step(); step();
    chk("R6 disabled", flush_busy, 0);
    wr(6'h08);
    step(); step();
    chk("R6 level", flush_busy, 0);
    flush_pin = 1'b0;
    step(); step();

    wr(6'h24);
    trig_evt = 1'b1;
    step();
    trig_evt = 1'b0;
    chk("R7 masked", flush_busy, 0);
    chk("R8 stop", stopped, 1);
    wr(6'h2E);
    chk("R10 man ignored", cfg_rdata[1], 0);
    trig_evt = 1'b1;
    flush_pin = 1'b1;
    ds_flush_req = 1'b1;
    step();
    trig_evt = 1'b0;
    ds_flush_req = 1'b0;
    step(); step();
    chk("R10 no flush", flush_busy, 0);
    flush_pin = 1'b0;
    restart();
    chk("R10 cleared", stopped, 0);

    wr(6'h0C);
    ds_flush_req = 1'b1;
    step();
    ds_flush_req = 1'b0;
    chk("R11 start", flush_valid, 1);
    trig_evt = 1'b1;
    flush_pin = 1'b1;
    step();
    trig_evt = 1'b0;
    step(); step();
    chk("R11 single", flush_valid, 1);
    flush_ready = 1'b1;
    step();
    flush_ready = 1'b0;
    chk("R11 done", flush_done, 1);
    step(); step(); step();
    chk("R11 no second", flush_busy, 0);
    flush_pin = 1'b0;
    step(); step();

    wr(6'h3D);
    chk("R12 read", cfg_rdata, 6'h3D);
    wr(6'h00);
    chk("R12 clear", cfg_rdata, 6'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule